// File: doc/BRIEF.md
# Static Memory Bus Controller with Programmable Phase Timing

This block drives an external asynchronous SRAM or parallel NOR device from a simple internal host port. The host raises a request with a write flag, an address and write data. The controller then runs chip select, output enable, write enable, an address-valid strobe, the address pins and a bidirectional data bus through a fixed sequence of phases: address setup, an optional address hold, data, and an optional turnaround gap. When the access ends it returns a one-cycle ready pulse. For a read, the read data is valid during that pulse.

Phase lengths come from a packed timing word, counted in controller clock cycles. A control word selects a multiplexed address/data bus, an 8- or 16-bit external data width, write permission, and an extended mode. In extended mode, writes take their timing from a second timing word. The controller captures both words when it accepts a request, so a change during an access only affects later accesses.

Top module: `extmem_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, `mem_ce_no`, `mem_oe_no`, `mem_we_no` and `mem_adv_no` are high, `mem_dq_oe_o` is low and `ready_o` is low.
- R2: Timing word fields are setup = bits [3:0], hold = bits [7:4], data = bits [15:8] and turnaround = bits [19:16]. Each of setup, hold and data lasts max(field,1) cycles. On a read in non-multiplexed mode, chip select is low for setup+data cycles, `mem_adv_no` is low for the setup cycles, and output enable is low for the data cycles.
- R3: With control bit 0 set (multiplexed mode), the address phase is setup+hold cycles. During it the address appears on `mem_dq_o` with `mem_dq_oe_o` high. Chip select is low for setup+hold+data cycles. Without bit 0, there is no hold phase.
- R4: Read data is taken from `mem_dq_i` in the last data cycle. It is presented on `rdata_o` together with a `ready_o` pulse of exactly one cycle, in the cycle after the data phase.
- R5: On a write with control bit 2 set, write enable is low for the data cycles and `mem_dq_o` carries the write data. `ready_o` pulses in the cycle write enable rises.
- R6: On a write with control bit 2 clear, write enable never goes low, while the access still runs its phases and returns `ready_o`.
- R7: After a read with turnaround field T, chip select stays high for at least T+1 cycles before the next access. After a write, no gap is inserted.
- R8: With control bit 3 set, writes use the setup, hold and data fields of `wr_tim_i`, and reads keep using `rd_tim_i`.
- R9: With control bit 3 clear, `wr_tim_i` has no effect, and writes use `rd_tim_i`.
- R10: The control and timing words are captured when a request is accepted. Changing them during an access does not alter that access.
- R11: With control bit 1 clear (8-bit bus), `rdata_o[15:8]` reads as zero and the upper data pins carry zero during a write. With bit 1 set, all 16 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 4 | Control word: [0] mux, [1] 16-bit, [2] write allow, [3] extended write timing |
| rd_tim_i | input | 32 | Timing word for reads, and for writes outside extended mode |
| wr_tim_i | input | 32 | Write timing word (extended mode only) |
| req_i | input | 1 | Access request, accepted when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Read data |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_adv_no | output | 1 | Address valid, active low |
| mem_addr_o | output | AW | Address pins |
| mem_dq_o | output | DW | Data pins, outbound |
| mem_dq_oe_o | output | 1 | Data pin drive enable |
| mem_dq_i | input | DW | Data pins, inbound |

## Verification
The bench uses the default parameters: a 16-bit address, a 16-bit data bus and 8-bit phase counters. With these, one port setting covers both the 8-bit and 16-bit bus modes, and data phases from a zero field up to several tens of cycles fit inside the run. Since the address and data widths are equal, the multiplexed address can be compared bit for bit against the address pins. The device model returns a known function of the address, which makes every read result predictable.

// File: rtl/extmem_pkg.sv
`timescale 1ns/1ps
package extmem_pkg;
  localparam int TIM_W   = 32;
  localparam int CTRL_W  = 4;
  localparam int CNT_W   = 8;
  localparam int SET_LSB = 0;
  localparam int SET_W   = 4;
  localparam int HLD_LSB = 4;
  localparam int HLD_W   = 4;
  localparam int DAT_LSB = 8;
  localparam int DAT_W   = 8;
  localparam int TRN_LSB = 16;
  localparam int TRN_W   = 4;
  localparam int CB_MUX  = 0;
  localparam int CB_WIDE = 1;
  localparam int CB_WREN = 2;
  localparam int CB_EXT  = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_DATA, PH_TURN
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] data;
    logic [CNT_W-1:0] turn;
    logic             mux;
    logic             wide;
    logic             wr_allow;
  } acc_cfg_t;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/extmem_cfg_sel.sv
`timescale 1ns/1ps
module extmem_cfg_sel
  import extmem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [TIM_W-1:0]  rd_tim_i,
  input  logic [TIM_W-1:0]  wr_tim_i,
  output acc_cfg_t          cfg_o
);
  logic [TIM_W-1:0] tim;
  acc_cfg_t         cfg_d, cfg_q;
  logic             unused_bits;

  assign unused_bits = ^{rd_tim_i[TIM_W-1:TRN_LSB+TRN_W], wr_tim_i[TIM_W-1:DAT_LSB+DAT_W]};

  always_comb begin
    tim            = (ctrl_i[CB_EXT] && we_i) ? wr_tim_i : rd_tim_i;
    cfg_d.setup    = at_least_one(CNT_W'(tim[SET_LSB +: SET_W]));
    cfg_d.hold     = at_least_one(CNT_W'(tim[HLD_LSB +: HLD_W]));
    cfg_d.data     = at_least_one(CNT_W'(tim[DAT_LSB +: DAT_W]));
    // bus turnaround only follows reads
    cfg_d.turn     = we_i ? '0 : CNT_W'(rd_tim_i[TRN_LSB +: TRN_W]);
    cfg_d.mux      = ctrl_i[CB_MUX];
    cfg_d.wide     = ctrl_i[CB_WIDE];
    cfg_d.wr_allow = ctrl_i[CB_WREN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{setup: CNT_W'(1), hold: CNT_W'(1), data: CNT_W'(1),
                 turn: '0, mux: 1'b0, wide: 1'b1, wr_allow: 1'b0};
    end else if (load_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
  p_len_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.setup != '0) && (cfg_q.data != '0) && (cfg_q.hold != '0));
endmodule

// File: rtl/extmem_phase_fsm.sv
`timescale 1ns/1ps
module extmem_phase_fsm
  import extmem_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  acc_cfg_t cfg_i,
  output phase_e   phase_o,
  output logic     accept_o,
  output logic     done_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cur_len;
  logic             last;

  always_comb begin
    unique case (ph_q)
      PH_SETUP: cur_len = cfg_i.setup;
      PH_HOLD:  cur_len = cfg_i.hold;
      PH_DATA:  cur_len = cfg_i.data;
      PH_TURN:  cur_len = cfg_i.turn;
      default:  cur_len = CNT_W'(1);
    endcase
  end

  assign last     = (cnt_q == cur_len - CNT_W'(1));
  assign accept_o = (ph_q == PH_IDLE) && req_i;
  assign done_o   = (ph_q == PH_DATA) && last;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (req_i) ph_d = PH_SETUP;
      PH_SETUP: if (last) ph_d = cfg_i.mux ? PH_HOLD : PH_DATA;
      PH_HOLD:  if (last) ph_d = PH_DATA;
      PH_DATA:  if (last) ph_d = (cfg_i.turn != '0) ? PH_TURN : PH_IDLE;
      PH_TURN:  if (last) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= (ph_d != ph_q || ph_q == PH_IDLE) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign phase_o = ph_q;

  p_hold_mux_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HOLD) |-> cfg_i.mux);
  p_turn_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_TURN) |-> ($past(ph_q) == PH_DATA || $past(ph_q) == PH_TURN));
  p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |-> (cnt_q < cur_len));
endmodule

// File: rtl/extmem_pin_drv.sv
`timescale 1ns/1ps
module extmem_pin_drv
  import extmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          accept_i,
  input  logic          done_i,
  input  acc_cfg_t      cfg_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          ce_no,
  output logic          oe_no,
  output logic          we_no,
  output logic          adv_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  localparam int NW = DW / 2;

  logic          we_q, ready_q, addr_ph;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, wfmt, rfmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      if (accept_i) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (done_i && !we_q) rdata_q <= rfmt;
      ready_q <= done_i;
    end
  end

  assign wfmt    = cfg_i.wide ? wdata_q : {{(DW-NW){1'b0}}, wdata_q[NW-1:0]};
  assign rfmt    = cfg_i.wide ? dq_i : {{(DW-NW){1'b0}}, dq_i[NW-1:0]};
  assign addr_ph = cfg_i.mux && (phase_i == PH_SETUP || phase_i == PH_HOLD);

  assign ce_no   = !(phase_i == PH_SETUP || phase_i == PH_HOLD || phase_i == PH_DATA);
  assign adv_no  = !(phase_i == PH_SETUP);
  assign oe_no   = !(phase_i == PH_DATA && !we_q);
  assign we_no   = !(phase_i == PH_DATA && we_q && cfg_i.wr_allow);
  assign dq_oe_o = addr_ph || !we_no;
  assign dq_o    = addr_ph ? DW'(addr_q) : wfmt;
  assign addr_o  = addr_q;
  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (oe_no && !ce_no));
  p_no_drive_on_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);
  p_ready_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_blocked_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> cfg_i.wr_allow);
  p_ready_after_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ce_no);
endmodule

// File: rtl/extmem_ctrl.sv
`timescale 1ns/1ps
module extmem_ctrl
  import extmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [TIM_W-1:0]  rd_tim_i,
  input  logic [TIM_W-1:0]  wr_tim_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              ready_o,
  output logic [DW-1:0]     rdata_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_adv_no,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DW-1:0]     mem_dq_i
);
  acc_cfg_t cfg;
  phase_e   phase;
  logic     accept, done;

  extmem_cfg_sel u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .we_i     (we_i),
    .ctrl_i   (ctrl_i),
    .rd_tim_i (rd_tim_i),
    .wr_tim_i (wr_tim_i),
    .cfg_o    (cfg)
  );

  extmem_phase_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .cfg_i    (cfg),
    .phase_o  (phase),
    .accept_o (accept),
    .done_o   (done)
  );

  extmem_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .accept_i (accept),
    .done_i   (done),
    .cfg_i    (cfg),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dq_i     (mem_dq_i),
    .ready_o  (ready_o),
    .rdata_o  (rdata_o),
    .ce_no    (mem_ce_no),
    .oe_no    (mem_oe_no),
    .we_no    (mem_we_no),
    .adv_no   (mem_adv_no),
    .addr_o   (mem_addr_o),
    .dq_o     (mem_dq_o),
    .dq_oe_o  (mem_dq_oe_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_no && $past(mem_ce_no) && !$past(accept)) |-> (mem_oe_no && mem_we_no && mem_adv_no));
endmodule

// File: tb/extmem_ctrl_tb.sv
`timescale 1ns/1ps
module extmem_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [3:0]    ctrl;
  logic [31:0]   rdt, wrt;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ready;
  logic [DW-1:0] rdata;
  logic          ce_n, oe_n, we_n, adv_n, dq_oe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] dq_o, dq_i;

  assign dq_i = maddr ^ 16'hA5C3;

  extmem_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .rd_tim_i(rdt), .wr_tim_i(wrt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_adv_no(adv_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  typedef struct {
    string       tag;
    bit          wr;
    int          ce, oe, wen, adv, mx;
    logic [15:0] a;
    logic [15:0] dat;
    bit          gchk;
    int          gap;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor
  int n_ce = 0, n_oe = 0, n_we = 0, n_adv = 0, n_mx = 0, addr_bad = 0;
  int gap = 0, last_gap = 0;
  bit prev_ce_low = 0;
  logic [15:0] wd_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce_n) begin
        if (!prev_ce_low) last_gap = gap;
        gap = 0;
        n_ce++;
      end else gap++;
      prev_ce_low = !ce_n;
      if (!oe_n) n_oe++;
      if (!we_n) begin n_we++; wd_seen = dq_o; end
      if (!adv_n) n_adv++;
      if (!ce_n && dq_oe && oe_n && we_n) begin
        n_mx++;
        if (dq_o != maddr) addr_bad++;
      end
      if (ready) begin
        if (q.size() == 0) chk("R4", "unexpected ready", 1, 0);
        else begin
          item_t e;
          e = q.pop_front();
          chk(e.tag, "ce cycles", n_ce, e.ce);
          chk(e.tag, "oe cycles", n_oe, e.oe);
          chk(e.tag, "we cycles", n_we, e.wen);
          chk(e.tag, "adv cycles", n_adv, e.adv);
          chk(e.tag, "mux addr cycles", n_mx, e.mx);
          chk(e.tag, "mux addr mismatches", addr_bad, 0);
          chk(e.tag, "addr pins", maddr, e.a);
          if (!e.wr) chk(e.tag, "read data", rdata, e.dat);
          else if (e.wen > 0) chk(e.tag, "write data", wd_seen, e.dat);
          if (e.gchk) chk(e.tag, "ce high gap", last_gap, e.gap);
        end
        n_ce = 0; n_oe = 0; n_we = 0; n_adv = 0; n_mx = 0; addr_bad = 0;
      end
    end
  end

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic start(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input string tag, input bit gchk, input int g);
    item_t       e;
    logic [31:0] t;
    int          s, h, dd;
    bit          mux, wide, allow;
    t     = (wr && ctrl[3]) ? wrt : rdt;
    s     = len1(int'(t[3:0]));
    h     = len1(int'(t[7:4]));
    dd    = len1(int'(t[15:8]));
    mux   = ctrl[0];
    wide  = ctrl[1];
    allow = ctrl[2];
    e.tag  = tag;
    e.wr   = wr;
    e.ce   = s + (mux ? h : 0) + dd;
    e.adv  = s;
    e.mx   = mux ? s + h : 0;
    e.oe   = wr ? 0 : dd;
    e.wen  = (wr && allow) ? dd : 0;
    e.a    = a;
    e.dat  = wr ? (wide ? d : (d & 16'h00FF))
                : (wide ? (a ^ 16'hA5C3) : ((a ^ 16'hA5C3) & 16'h00FF));
    e.gchk = gchk;
    e.gap  = g;
    q.push_back(e);
    we = wr; addr = a; wdata = d; req = 1'b1;
    do @(negedge clk); while (ce_n);
    req = 1'b0;
  endtask

  task automatic finish_acc;
    do @(negedge clk); while (!ready);
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input string tag, input bit gchk, input int g);
    start(wr, a, d, tag, gchk, g);
    finish_acc();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R4 watchdog actual=%0d expected<=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    ctrl = 4'b0110; rdt = 32'h0; wrt = 32'h0FFF_FFFF;
    idle(3);
    chk("R1", "ce in reset", ce_n, 1);
    chk("R1", "dq_oe in reset", dq_oe, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1", "ce idle", ce_n, 1);
    chk("R1", "oe idle", oe_n, 1);
    chk("R1", "we idle", we_n, 1);
    chk("R1", "adv idle", adv_n, 1);
    chk("R1", "dq_oe idle", dq_oe, 0);
    chk("R1", "ready idle", ready, 0);

    // R2 / R4: non-mux read, set 2 data 3
    rdt = 32'h0000_0322;
    access(0, 16'h1234, 0, "R2", 0, 0);
    access(0, 16'hBEEF, 0, "R4", 1, 1);
    // R2: zero fields give one cycle each
    rdt = 32'h0;
    access(0, 16'h0F0F, 0, "R2_zero", 1, 1);
    // R5: write, set 3 data 4
    rdt = 32'h0000_0403;
    access(1, 16'h2222, 16'hCAFE, "R5", 1, 1);
    access(1, 16'h2224, 16'h1357, "R5_b2b", 1, 1);
    // R2: long data phase
    rdt = 32'h0000_1401;
    access(0, 16'h7777, 0, "R2_long", 1, 1);
    // R7: turnaround 3
    rdt = 32'h0003_0201;
    access(0, 16'h0101, 0, "R7", 1, 1);
    access(0, 16'h0102, 0, "R7_rd_rd", 1, 4);
    access(1, 16'h0103, 16'h5A5A, "R7_rd_wr", 1, 4);
    access(0, 16'h0104, 0, "R7_wr_rd", 1, 1);
    idle(6);
    // R3: multiplexed, set 2 hold 3 data 2
    ctrl = 4'b0111; rdt = 32'h0000_0232;
    access(0, 16'h4321, 0, "R3_rd", 0, 0);
    access(1, 16'h8765, 16'h0F1E, "R3_wr", 1, 1);
    rdt = 32'h0000_0100;
    access(0, 16'h9999, 0, "R3_min", 1, 1);
    // R11: 8-bit bus
    ctrl = 4'b0100; rdt = 32'h0000_0211;
    access(0, 16'hA1B2, 0, "R11_rd", 1, 1);
    access(1, 16'hA1B4, 16'hFFEE, "R11_wr", 1, 1);
    ctrl = 4'b0101;
    access(0, 16'h3C3C, 0, "R11_mux", 1, 1);
    // R6: writes blocked
    ctrl = 4'b0010; rdt = 32'h0000_0302;
    access(1, 16'h5555, 16'hDEAD, "R6", 1, 1);
    ctrl = 4'b0011;
    access(1, 16'h5557, 16'hBEEF, "R6_mux", 1, 1);
    // R8: extended write timing
    ctrl = 4'b1110; rdt = 32'h0000_0201; wrt = 32'h0000_0623;
    access(1, 16'h6000, 16'h1111, "R8_wr", 1, 1);
    access(0, 16'h6002, 0, "R8_rd", 1, 1);
    ctrl = 4'b1111;
    access(1, 16'h6004, 16'h2222, "R8_mux", 1, 1);
    // R9: extended off, write word ignored
    ctrl = 4'b0110; wrt = 32'h0000_0905;
    access(1, 16'h7000, 16'h3333, "R9", 1, 1);
    wrt = 32'h0FFF_FFFF;
    access(1, 16'h7002, 16'h4444, "R9_ff", 1, 1);
    // R10: change config mid-access
    ctrl = 4'b0110; rdt = 32'h0000_0302;
    start(0, 16'h8000, 0, "R10", 1, 1);
    ctrl = 4'b0001; rdt = 32'h0002_0905;
    finish_acc();
    access(0, 16'h8002, 0, "R10_next", 1, 1);
    idle(8);
    chk("R4", "pending items", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule